// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. It drives a trial code to an external DAC and reads back a one-bit comparator verdict that says whether the trial is above the sampled input. Starting from the top bit, it sets one bit per step, keeps or drops it according to the verdict, and latches the finished code. One active-low control line, `cvt_n`, both starts and blanks the converter. Holding it high keeps the converter in blanked standby. Taking it low starts a conversion. Raising it again during a conversion pauses or discards that conversion, depending on how long it stays high. Raising it after a result is ready releases the result.

When the last bit has been decided, an active-low ready flag falls. A fixed number of clocks later, an output-enable rises and the result appears on the data bus. The three-state pins are modelled as a data bus plus that enable, and the bus reads zero while the enable is low. A range select input chooses how the code is read on a second, signed output: as a plain binary value, or as offset binary centred on zero. All analog-domain delays are given as counts of system clocks.

Top module: `sar_ctrl_top`

## Requirements
- R1: A conversion starts with `trial_code` = 1000000000 on the clock edge after the starting low sample. It makes exactly 10 bit decisions, from the top bit down, one every STEP_CYC clocks.
- R2: At a decision edge, the bit under test is cleared if `cmp_over` = 1 and kept if `cmp_over` = 0. The next lower bit is set at the same edge. With an ideal comparator, the final code is the largest code that is not above the input.
- R3: After reset, `rdy_n` = 1, `data_oe` = 0, `data_out` = 0 and `value_out` = 0.
- R4: From standby, a conversion starts only on a low sample of `cvt_n` that follows at least MIN_PULSE consecutive high samples. A low after a shorter high run is ignored: `rdy_n` stays 1 and `trial_code` does not change.
- R5: While a conversion runs or is paused, `rdy_n` stays 1 and `data_oe` stays 0.
- R6: `rdy_n` falls at the edge of the final decision. `data_oe` rises DRIVE_DLY edges later. While `data_oe` is 1, `data_out` carries the final code. While `data_oe` is 0, `data_out` is 0.
- R7: The result, together with `rdy_n` = 0, is held for as long as `cvt_n` stays low.
- R8: Once a result is ready, RELEASE_DLY consecutive high samples of `cvt_n` return `rdy_n` to 1 and `data_oe` to 0 at the edge of the last of those samples. A shorter high run leaves the result and the flags unchanged.
- R9: A high sample during a conversion pauses it with `trial_code` frozen. A low sample that arrives before MIN_PULSE consecutive highs resumes the conversion where it stopped.
- R10: MIN_PULSE consecutive high samples during a conversion discard it. The next low then starts a fresh conversion from 1000000000.
- R11: `value_out` (11 bits, two's complement) equals the code zero-extended when `bipolar_sel` = 0. When `bipolar_sel` = 1 it equals the code minus 512, so 0000000000 reads -512, 1000000000 reads 0 and 1111111111 reads 511. It is 0 while `data_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cvt_n | input | 1 | Blank (high) / convert (low) control line |
| bipolar_sel | input | 1 | 1: offset-binary reading, 0: plain binary reading |
| cmp_over | input | 1 | Comparator verdict: trial is above the input |
| trial_code | output | 10 | Trial code to the DAC |
| rdy_n | output | 1 | Active-low result-ready flag |
| data_oe | output | 1 | Output enable for the result bus |
| data_out | output | 10 | Result code, zero while disabled |
| value_out | output | 11 | Signed reading of the result, zero while disabled |

## Verification
The input is swept across zero, full scale, an irregular mid value and the points around mid-scale. Together these show that each decision either drops or keeps its bit, and that no bit is skipped or decided twice. The control line is then given high runs just under and just over each threshold: a short glitch while the result is held, a release run that is too short to re-arm, a brief pause in mid-conversion, and a long abort. Each of these runs separates pausing from discarding, and releasing from re-arming. The bipolar cases read back the three anchor codes and one code just below mid-scale, which checks the offset reading at both ends and at its sign change.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HALT = 2'd2,
    ST_DONE = 2'd3
  } sar_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/sar_pulse_filter.sv
module sar_pulse_filter #(
  parameter int MIN_PULSE   = 8,
  parameter int RELEASE_DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  output logic armed,
  output logic clr_hit,
  output logic rel_hit
);
  localparam int SAT = sar_pkg::imax(MIN_PULSE, RELEASE_DLY);
  localparam int CW  = sar_pkg::cnt_width(SAT);

  logic [CW-1:0] hcnt_q;
  logic [CW-1:0] hcnt_nx;

  always_comb begin
    if (!line_hi)                hcnt_nx = '0;
    else if (hcnt_q == CW'(SAT)) hcnt_nx = hcnt_q;
    else                         hcnt_nx = hcnt_q + 1'b1;
  end

  // Standby assumes the line has been high long enough to arm.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= CW'(SAT);
    else        hcnt_q <= hcnt_nx;
  end

  assign armed   = (hcnt_q  >= CW'(MIN_PULSE));
  assign clr_hit = (hcnt_nx >= CW'(MIN_PULSE));
  assign rel_hit = (hcnt_nx >= CW'(RELEASE_DLY));

endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
  parameter int N_BITS   = 10,
  parameter int STEP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic              cmp_over,
  output logic [N_BITS-1:0] trial,
  output logic [N_BITS-1:0] decided,
  output logic              last_dec
);
  localparam int IW = sar_pkg::cnt_width(N_BITS - 1);
  localparam int SW = sar_pkg::cnt_width(STEP_CYC - 1);
  localparam logic [N_BITS-1:0] TOP_ONLY = {1'b1, {(N_BITS-1){1'b0}}};

  logic [N_BITS-1:0] trial_q;
  logic [IW-1:0]     bit_q;
  logic [SW-1:0]     scnt_q;
  logic [N_BITS-1:0] sel_mask;
  logic              step_end;

  for (genvar g = 0; g < N_BITS; g++) begin : g_sel
    assign sel_mask[g] = (bit_q == IW'(g));
  end

  assign step_end = run && (scnt_q == SW'(STEP_CYC - 1));
  assign decided  = cmp_over ? (trial_q & ~sel_mask) : trial_q;
  assign last_dec = step_end && (bit_q == '0);
  assign trial    = trial_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      bit_q   <= '0;
      scnt_q  <= '0;
    end else if (load) begin
      trial_q <= TOP_ONLY;
      bit_q   <= IW'(N_BITS - 1);
      scnt_q  <= '0;
    end else if (step_end) begin
      scnt_q <= '0;
      if (bit_q == '0) begin
        trial_q <= decided;
      end else begin
        trial_q <= decided | (sel_mask >> 1);
        bit_q   <= bit_q - 1'b1;
      end
    end else if (run) begin
      scnt_q <= scnt_q + 1'b1;
    end
  end

  AST_KEEP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_end && !cmp_over) |=> (trial_q >= $past(trial_q))); // R2
  AST_DROP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_end && cmp_over) |=> (trial_q < $past(trial_q))); // R2
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(trial_q)); // R9

endmodule

// File: rtl/sar_out_gate.sv
module sar_out_gate #(
  parameter int N_BITS    = 10,
  parameter int DRIVE_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_done,
  input  logic              capture,
  input  logic [N_BITS-1:0] code_in,
  input  logic              bipolar,
  output logic              data_oe,
  output logic [N_BITS-1:0] data_out,
  output logic [N_BITS:0]   value_out
);
  localparam int DW = sar_pkg::cnt_width(DRIVE_DLY);

  logic [N_BITS-1:0] res_q;
  logic [DW-1:0]     dcnt_q;

  // Offset binary: invert the top bit and sign-extend.
  function automatic logic [N_BITS:0] to_value(input logic [N_BITS-1:0] c, input logic bip);
    if (bip) return {~c[N_BITS-1], ~c[N_BITS-1], c[N_BITS-2:0]};
    else     return {1'b0, c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (capture) res_q <= code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dcnt_q <= '0;
    else if (!in_done)                   dcnt_q <= '0;
    else if (dcnt_q != DW'(DRIVE_DLY))   dcnt_q <= dcnt_q + 1'b1;
  end

  assign data_oe   = in_done && (dcnt_q == DW'(DRIVE_DLY));
  assign data_out  = data_oe ? res_q : '0;
  assign value_out = data_oe ? to_value(res_q, bipolar) : '0;

  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && in_done) |=> (!data_oe || $stable(data_out))); // R7
  AST_OE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(in_done)); // R6

endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top #(
  parameter int N_BITS      = 10,
  parameter int STEP_CYC    = 2,
  parameter int DRIVE_DLY   = 3,
  parameter int RELEASE_DLY = 6,
  parameter int MIN_PULSE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cvt_n,
  input  logic              bipolar_sel,
  input  logic              cmp_over,
  output logic [N_BITS-1:0] trial_code,
  output logic              rdy_n,
  output logic              data_oe,
  output logic [N_BITS-1:0] data_out,
  output logic [N_BITS:0]   value_out
);
  import sar_pkg::*;

  localparam logic [N_BITS-1:0] TOP_ONLY = {1'b1, {(N_BITS-1){1'b0}}};

  sar_st_e           st_q, st_nx;
  logic              armed, clr_hit, rel_hit;
  logic              start_evt, run_en, last_dec;
  logic [N_BITS-1:0] decided;

  sar_pulse_filter #(
    .MIN_PULSE  (MIN_PULSE),
    .RELEASE_DLY(RELEASE_DLY)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_hi(cvt_n),
    .armed  (armed),
    .clr_hit(clr_hit),
    .rel_hit(rel_hit)
  );

  assign start_evt = (st_q == ST_IDLE) && !cvt_n && armed;
  assign run_en    = (st_q == ST_CONV) && !cvt_n;

  sar_step_engine #(
    .N_BITS  (N_BITS),
    .STEP_CYC(STEP_CYC)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_evt),
    .run     (run_en),
    .cmp_over(cmp_over),
    .trial   (trial_code),
    .decided (decided),
    .last_dec(last_dec)
  );

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE: if (start_evt) st_nx = ST_CONV;
      ST_CONV: begin
        if (cvt_n)         st_nx = ST_HALT;
        else if (last_dec) st_nx = ST_DONE;
      end
      ST_HALT: begin
        if (!cvt_n)        st_nx = ST_CONV;
        else if (clr_hit)  st_nx = ST_IDLE;
      end
      ST_DONE: if (cvt_n && rel_hit) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  assign rdy_n = (st_q != ST_DONE);

  sar_out_gate #(
    .N_BITS   (N_BITS),
    .DRIVE_DLY(DRIVE_DLY)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_done  (st_q == ST_DONE),
    .capture  (last_dec),
    .code_in  (decided),
    .bipolar  (bipolar_sel),
    .data_oe  (data_oe),
    .data_out (data_out),
    .value_out(value_out)
  );

  AST_START_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (trial_code == TOP_ONLY)); // R1
  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !armed) |=> (st_q == ST_IDLE)); // R4
  AST_CONV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONV || st_q == ST_HALT) |-> !data_oe); // R5
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    last_dec |=> !rdy_n); // R6
  AST_OE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !rdy_n); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && cvt_n && rel_hit) |=> (rdy_n && !data_oe)); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |=> $stable(trial_code)); // R9

endmodule

// File: tb/sar_ctrl_top_tb.sv
module sar_ctrl_top_tb_top;
  localparam int NB  = 10;
  localparam int STP = 2;
  localparam int DRV = 3;
  localparam int REL = 6;
  localparam int MINP = 8;
  localparam int HSAT = (MINP > REL) ? MINP : REL;
  localparam int CONV_LEN = NB * STP + DRV + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cvt_n = 1'b1;
  logic bipolar_sel = 1'b0;
  logic cmp_over;
  logic [NB-1:0] trial_code;
  logic rdy_n, data_oe;
  logic [NB-1:0] data_out;
  logic [NB:0] value_out;

  int vin = 0;
  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_st = 0;   // 0 standby, 1 converting, 2 paused, 3 result ready
  int m_h = HSAT;
  int m_trial = 0;
  int m_bit = 0;
  int m_sc = 0;
  int m_res = 0;
  int m_dc = 0;

  always #2.5 clk = ~clk;

  assign cmp_over = (int'(trial_code) > vin);

  sar_ctrl_top #(
    .N_BITS(NB), .STEP_CYC(STP), .DRIVE_DLY(DRV),
    .RELEASE_DLY(REL), .MIN_PULSE(MINP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cvt_n(cvt_n), .bipolar_sel(bipolar_sel),
    .cmp_over(cmp_over), .trial_code(trial_code), .rdy_n(rdy_n),
    .data_oe(data_oe), .data_out(data_out), .value_out(value_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit hi);
    int hn;
    bit c;
    hn = hi ? ((m_h + 1 > HSAT) ? HSAT : m_h + 1) : 0;
    c  = (m_trial > vin);
    case (m_st)
      0: if (!hi && m_h >= MINP) begin
           m_st = 1; m_trial = 1 << (NB - 1); m_bit = NB - 1; m_sc = 0;
         end
      1: if (hi) m_st = 2;
         else if (m_sc == STP - 1) begin
           if (c) m_trial = m_trial - (1 << m_bit);
           if (m_bit == 0) begin
             m_st = 3; m_res = m_trial; m_dc = 0;
           end else begin
             m_bit = m_bit - 1; m_trial = m_trial + (1 << m_bit); m_sc = 0;
           end
         end else m_sc++;
      2: if (!hi) m_st = 1; else if (hn >= MINP) m_st = 0;
      default: begin
        if (m_dc < DRV) m_dc++;
        if (hi && hn >= REL) m_st = 0;
      end
    endcase
    m_h = hn;
  endtask

  task automatic compare_all();
    bit oe;
    int val;
    oe  = (m_st == 3) && (m_dc >= DRV);
    val = !oe ? 0 : (bipolar_sel ? m_res - 512 : m_res);
    chk("R2", "trial_code", int'(trial_code), m_trial);
    chk("R6", "rdy_n", int'(rdy_n), (m_st == 3) ? 0 : 1);
    chk("R6", "data_oe", int'(data_oe), int'(oe));
    chk("R6", "data_out", int'(data_out), oe ? m_res : 0);
    chk("R11", "value_out", int'($signed(value_out)), val);
  endtask

  task automatic cyc(input bit hi);
    cvt_n = hi;
    #1;
    model_step(hi);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_conv(input int code, input bit bip, input string req);
    vin = code;
    bipolar_sel = bip;
    repeat (MINP + 2) cyc(1'b1);
    repeat (5) cyc(1'b0);
    chk("R5", "rdy_n mid-conversion", int'(rdy_n), 1);
    repeat (CONV_LEN - 5) cyc(1'b0);
    chk(req, "final code", int'(data_out), code);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0] held;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk("R3", "rdy_n", int'(rdy_n), 1);
    chk("R3", "data_oe", int'(data_oe), 0);
    chk("R3", "data_out", int'(data_out), 0);
    chk("R3", "value_out", int'(value_out), 0);
    rst_n = 1'b1;

    // R1 R2: irregular, zero and full-scale inputs
    run_conv(679, 1'b0, "R1");
    repeat (20) cyc(1'b0);
    chk("R7", "result held", int'(data_out), 679);
    chk("R7", "rdy_n held", int'(rdy_n), 0);

    // R8: short high run leaves the result
    repeat (REL - 2) cyc(1'b1);
    repeat (4) cyc(1'b0);
    chk("R8", "result after glitch", int'(data_out), 679);

    run_conv(0, 1'b0, "R2");
    chk("R8", "rdy_n low after new result", int'(rdy_n), 0);
    run_conv(1023, 1'b0, "R2");

    // R4: release without re-arming, then low: no start
    repeat (REL + 1) cyc(1'b1);
    chk("R8", "rdy_n released", int'(rdy_n), 1);
    chk("R8", "data_oe released", int'(data_oe), 0);
    held = trial_code;
    repeat (30) cyc(1'b0);
    chk("R4", "no start rdy_n", int'(rdy_n), 1);
    chk("R4", "no start trial", int'(trial_code), int'(held));

    // R9: pause and resume
    vin = 345;
    repeat (MINP + 2) cyc(1'b1);
    repeat (7) cyc(1'b0);
    held = trial_code;
    repeat (3) cyc(1'b1);
    chk("R9", "trial frozen", int'(trial_code), int'(held));
    repeat (CONV_LEN) cyc(1'b0);
    chk("R9", "resumed code", int'(data_out), 345);

    // R10: abort and restart
    vin = 200;
    repeat (MINP + 2) cyc(1'b1);
    repeat (9) cyc(1'b0);
    repeat (MINP + 1) cyc(1'b1);
    chk("R10", "aborted rdy_n", int'(rdy_n), 1);
    cyc(1'b0);
    chk("R10", "restart trial", int'(trial_code), 512);
    repeat (CONV_LEN) cyc(1'b0);
    chk("R10", "restarted code", int'(data_out), 200);

    // R11: offset-binary readings
    run_conv(0, 1'b1, "R11");
    chk("R11", "bipolar min", int'($signed(value_out)), -512);
    run_conv(512, 1'b1, "R11");
    chk("R11", "bipolar mid", int'($signed(value_out)), 0);
    run_conv(1023, 1'b1, "R11");
    chk("R11", "bipolar max", int'($signed(value_out)), 511);
    run_conv(511, 1'b1, "R11");
    chk("R11", "bipolar below mid", int'($signed(value_out)), -1);
    bipolar_sel = 1'b0;
    cyc(1'b0);
    chk("R11", "unipolar reread", int'(value_out), 511);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule